// File: doc/BRIEF.md
# Microcontroller power mode controller

This block governs the low-power states of a small 8-bit microcontroller core. It owns an 8-bit power control register that the CPU writes over a simple register strobe. That register holds an idle request, a power-down request, two general-purpose flags, a watchdog-reload permission bit, an address-latch suppression bit and a serial baud-doubling bit. From the register state the block drives clock enables for the CPU, for the peripherals and for an attached CAN controller. It also drives a registered address-latch strobe and a registered watchdog-reload acceptance pulse.

Idle stops only the CPU clock. It ends when an enabled interrupt is pending, when a qualified external reset arrives or when the watchdog overflows. Power-down stops every clock and ends only on a reset. A separate CAN command register carries a sleep bit that turns off the CAN clock. That bit clears itself as soon as either CAN receive line shows a dominant (low) level. The CPU core, the oscillator, the baud generator and the watchdog counter sit outside this block and appear here only as handshake signals.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst_i` is high, every register is cleared. `sys_rst_o` is high one cycle after each edge that samples the reset. After reset the power register reads 0x00, the CAN register reads 0x00 and all three clock enables are 1.
- R2: The power register is at address 0x87. Bit 7 drives `baud_dbl_o`. Bits 3 and 2 are general flags that are stored and read back with no side effect, and they may be written together with idle (bit 0). Bit 6 is reserved and always reads 0.
- R3: A write with bit 1 (power-down) and bit 0 (idle) both set, while `ew_i` is high, enters power-down only. The register reads bit 1 set and bit 0 clear, and the CPU, peripheral and CAN clock enables all drop to 0.
- R4: While `ew_i` is low, a write of 1 to bit 1 leaves power-down at 0. If bit 0 is set in the same write, idle is entered.
- R5: In idle the CPU clock enable is 0 and the peripheral clock enable stays 1.
- R6: While idle, an interrupt with both its request and enable bits high clears bit 0 at the next edge, and the CPU clock resumes. A pending request whose enable is low does not end idle.
- R7: `ext_rst_i` causes an internal reset only on the 24th consecutive clock edge at which it is sampled high. A pulse of 23 cycles changes nothing.
- R8: A one-cycle `wdt_ovf_i` causes an internal reset at that edge. The reset clears idle and power-down, and `sys_rst_o` is high in the following cycle.
- R9: `wdt_load_i` is accepted only while bit 4 (watchdog-load permission) is 1. An accepted load gives a one-cycle `wdt_reload_o` pulse in the next cycle and clears bit 4. A refused load gives no pulse.
- R10: While bit 5 is 0, `ale_o` follows `ale_i` one cycle later. While bit 5 is 1, `ale_o` is held at 0.
- R11: The CAN register is at address 0xD9, with the sleep bit at position 4. Writing 1 there sets sleep and drops the CAN clock enable, and the bit reads back as 1. Writing 0 clears it. A 0 on either bit of `can_rx_i` clears it at the next edge.
- R12: Power-down is not ended by an interrupt. It ends only through R1, R7 or R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_i | input | 1 | Synchronous power-on reset, active high |
| ext_rst_i | input | 1 | Raw external reset pin, active high |
| wdt_ovf_i | input | 1 | Watchdog overflow strobe |
| ew_i | input | 1 | Power-down permission pin |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational on the address) |
| irq_req_i | input | 4 | Interrupt requests |
| irq_en_i | input | 4 | Interrupt enables |
| wdt_load_i | input | 1 | CPU attempts a watchdog reload |
| wdt_reload_o | output | 1 | Accepted watchdog reload pulse |
| ale_i | input | 1 | Address latch strobe from the core |
| ale_o | output | 1 | Address latch strobe to the pin |
| can_rx_i | input | 2 | CAN receive lines, 0 is dominant |
| baud_dbl_o | output | 1 | Baud doubling to the serial port |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| periph_clk_en_o | output | 1 | Peripheral and interrupt clock enable |
| can_clk_en_o | output | 1 | CAN controller clock enable |
| sys_rst_o | output | 1 | Internal reset to the rest of the chip |

## Verification
The bench builds the block with its default values: a 24-cycle reset qualification, four interrupt lines and two CAN receive lines. With four lines, a request whose enable is low can sit next to an enabled one. With the real 24-cycle length, the 23-versus-24 boundary can be reached exactly within a short run. The two receive lines let each line clear the sleep bit on its own.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int BIT_IDL  = 0;
  localparam int BIT_PD   = 1;
  localparam int BIT_GF0  = 2;
  localparam int BIT_GF1  = 3;
  localparam int BIT_WLE  = 4;
  localparam int BIT_ALES = 5;
  localparam int BIT_RSV  = 6;
  localparam int BIT_BDBL = 7;
  localparam int CAN_SLEEP_BIT = 4;

  typedef struct packed {
    logic bdbl;
    logic rsv;
    logic ales;
    logic wle;
    logic gf1;
    logic gf0;
    logic pd;
    logic idl;
  } pcon_t;
endpackage

// File: rtl/pmc_rst_qual.sv
module pmc_rst_qual #(
  parameter int RST_CYCLES = 24
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic ext_rst_i,
  input  logic wdt_ovf_i,
  output logic int_rst_o,
  output logic sys_rst_o
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RST_CYCLES);
  localparam logic [CNT_W-1:0] CNT_HIT = CNT_W'(RST_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             hit;
  logic             sys_rst_q;

  // cnt_q holds how many earlier consecutive edges saw the pin high
  always_ff @(posedge clk_i) begin
    if (rst_i)            cnt_q <= '0;
    else if (!ext_rst_i)  cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign hit       = ext_rst_i && (cnt_q >= CNT_HIT);
  assign int_rst_o = rst_i | hit | wdt_ovf_i;

  always_ff @(posedge clk_i) begin
    sys_rst_q <= int_rst_o;
  end

  assign sys_rst_o = sys_rst_q;
endmodule

// File: rtl/pmc_pcon_reg.sv
module pmc_pcon_reg
  import pmc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       wr_en_i,
  input  logic [7:0] wdata_i,
  input  logic       ew_i,
  input  logic       wake_i,
  input  logic       wdt_load_i,
  output pcon_t      pcon_o
);
  pcon_t pcon_q;
  logic  pd_req;
  logic  unused_rsv;

  assign unused_rsv = wdata_i[BIT_RSV];
  assign pd_req     = wdata_i[BIT_PD] & ew_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pcon_q <= '0;
    end else if (wr_en_i) begin
      pcon_q.bdbl <= wdata_i[BIT_BDBL];
      pcon_q.rsv  <= 1'b0;
      pcon_q.ales <= wdata_i[BIT_ALES];
      pcon_q.wle  <= wdata_i[BIT_WLE];
      pcon_q.gf1  <= wdata_i[BIT_GF1];
      pcon_q.gf0  <= wdata_i[BIT_GF0];
      // power-down is sticky until reset and outranks idle
      pcon_q.pd   <= pcon_q.pd | pd_req;
      pcon_q.idl  <= wdata_i[BIT_IDL] & ~pd_req & ~pcon_q.pd;
    end else begin
      if (wake_i && pcon_q.idl)        pcon_q.idl <= 1'b0;
      if (wdt_load_i && pcon_q.wle)    pcon_q.wle <= 1'b0;
    end
  end

  assign pcon_o = pcon_q;
endmodule

// File: rtl/pmc_can_sleep.sv
module pmc_can_sleep #(
  parameter int NUM_RX = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic              wbit_i,
  input  logic [NUM_RX-1:0] can_rx_i,
  output logic              sleep_o
);
  logic sleep_q;
  logic dominant;

  assign dominant = ~(&can_rx_i);

  always_ff @(posedge clk_i) begin
    if (rst_i)         sleep_q <= 1'b0;
    else if (dominant) sleep_q <= 1'b0;
    else if (wr_en_i)  sleep_q <= wbit_i;
  end

  assign sleep_o = sleep_q;
endmodule

// File: rtl/pmc_out_stage.sv
module pmc_out_stage (
  input  logic clk_i,
  input  logic rst_i,
  input  logic ale_i,
  input  logic ale_sup_i,
  input  logic wdt_load_i,
  input  logic wle_i,
  output logic ale_o,
  output logic wdt_reload_o
);
  logic ale_q;
  logic reload_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ale_q    <= 1'b0;
      reload_q <= 1'b0;
    end else begin
      ale_q    <= ale_sup_i ? 1'b0 : ale_i;
      reload_q <= wdt_load_i & wle_i;
    end
  end

  assign ale_o        = ale_q;
  assign wdt_reload_o = reload_q;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int          RST_CYCLES  = 24,
  parameter int          NUM_IRQ     = 4,
  parameter int          NUM_CAN_RX  = 2,
  parameter int          ADDR_W      = 8,
  parameter logic [7:0]  PCON_ADDR   = 8'h87,
  parameter logic [7:0]  CANCMD_ADDR = 8'hD9
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  ext_rst_i,
  input  logic                  wdt_ovf_i,
  input  logic                  ew_i,
  input  logic                  reg_wr_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic [7:0]            reg_wdata_i,
  output logic [7:0]            reg_rdata_o,
  input  logic [NUM_IRQ-1:0]    irq_req_i,
  input  logic [NUM_IRQ-1:0]    irq_en_i,
  input  logic                  wdt_load_i,
  output logic                  wdt_reload_o,
  input  logic                  ale_i,
  output logic                  ale_o,
  input  logic [NUM_CAN_RX-1:0] can_rx_i,
  output logic                  baud_dbl_o,
  output logic                  cpu_clk_en_o,
  output logic                  periph_clk_en_o,
  output logic                  can_clk_en_o,
  output logic                  sys_rst_o
);
  localparam logic [ADDR_W-1:0] PCON_A = ADDR_W'(PCON_ADDR);
  localparam logic [ADDR_W-1:0] CAN_A  = ADDR_W'(CANCMD_ADDR);

  logic               int_rst;
  logic               pcon_wr;
  logic               can_wr;
  logic               wake;
  logic               can_sleep;
  logic [NUM_IRQ-1:0] irq_hit;
  pcon_t              pcon;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq
    assign irq_hit[g] = irq_req_i[g] & irq_en_i[g];
  end
  assign wake = |irq_hit;

  assign pcon_wr = reg_wr_i && (reg_addr_i == PCON_A);
  assign can_wr  = reg_wr_i && (reg_addr_i == CAN_A);

  pmc_rst_qual #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .ext_rst_i (ext_rst_i),
    .wdt_ovf_i (wdt_ovf_i),
    .int_rst_o (int_rst),
    .sys_rst_o (sys_rst_o)
  );

  pmc_pcon_reg u_pcon (
    .clk_i      (clk_i),
    .rst_i      (int_rst),
    .wr_en_i    (pcon_wr),
    .wdata_i    (reg_wdata_i),
    .ew_i       (ew_i),
    .wake_i     (wake),
    .wdt_load_i (wdt_load_i),
    .pcon_o     (pcon)
  );

  pmc_can_sleep #(.NUM_RX(NUM_CAN_RX)) u_can (
    .clk_i    (clk_i),
    .rst_i    (int_rst),
    .wr_en_i  (can_wr),
    .wbit_i   (reg_wdata_i[CAN_SLEEP_BIT]),
    .can_rx_i (can_rx_i),
    .sleep_o  (can_sleep)
  );

  pmc_out_stage u_out (
    .clk_i        (clk_i),
    .rst_i        (int_rst),
    .ale_i        (ale_i),
    .ale_sup_i    (pcon.ales),
    .wdt_load_i   (wdt_load_i),
    .wle_i        (pcon.wle),
    .ale_o        (ale_o),
    .wdt_reload_o (wdt_reload_o)
  );

  always_comb begin
    reg_rdata_o = 8'h00;
    if (reg_addr_i == PCON_A)     reg_rdata_o = pcon;
    else if (reg_addr_i == CAN_A) reg_rdata_o[CAN_SLEEP_BIT] = can_sleep;
  end

  assign baud_dbl_o      = pcon.bdbl;
  assign cpu_clk_en_o    = ~(pcon.idl | pcon.pd);
  assign periph_clk_en_o = ~pcon.pd;
  assign can_clk_en_o    = ~(can_sleep | pcon.pd);
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int NUM_CAN_RX = 2
) (
  input logic                  clk_i,
  input logic                  rst_i,
  input logic                  ext_rst_i,
  input logic                  wdt_ovf_i,
  input logic                  wake,
  input logic                  pcon_wr,
  input logic                  idl,
  input logic                  pd,
  input logic                  ales,
  input logic                  can_sleep,
  input logic                  sys_rst_o,
  input logic                  wdt_load_i,
  input logic                  wdt_reload_o,
  input logic                  ale_o,
  input logic [NUM_CAN_RX-1:0] can_rx_i,
  input logic                  cpu_clk_en_o,
  input logic                  periph_clk_en_o
);
  // R3
  pd_excl_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    pd |-> !idl);

  // R5
  idle_gates_cpu_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    idl |-> (!cpu_clk_en_o && periph_clk_en_o));

  // R6
  irq_wake_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (idl && wake && !pcon_wr) |=> !idl);

  // R7
  no_spurious_rst_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!ext_rst_i && !wdt_ovf_i) |=> !sys_rst_o);

  // R8
  wdt_rst_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    wdt_ovf_i |=> (sys_rst_o && !idl && !pd));

  // R9
  reload_cause_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    wdt_reload_o |-> $past(wdt_load_i));

  // R10
  ale_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ales |=> !ale_o);

  // R11
  can_dom_wake_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!(&can_rx_i)) |=> !can_sleep);

  // R12
  pd_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (pd && !ext_rst_i && !wdt_ovf_i) |=> pd);
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.NUM_CAN_RX(NUM_CAN_RX)) u_chk (
  .clk_i           (clk_i),
  .rst_i           (rst_i),
  .ext_rst_i       (ext_rst_i),
  .wdt_ovf_i       (wdt_ovf_i),
  .wake            (wake),
  .pcon_wr         (pcon_wr),
  .idl             (pcon.idl),
  .pd              (pcon.pd),
  .ales            (pcon.ales),
  .can_sleep       (can_sleep),
  .sys_rst_o       (sys_rst_o),
  .wdt_load_i      (wdt_load_i),
  .wdt_reload_o    (wdt_reload_o),
  .ale_o           (ale_o),
  .can_rx_i        (can_rx_i),
  .cpu_clk_en_o    (cpu_clk_en_o),
  .periph_clk_en_o (periph_clk_en_o)
);

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RST_CYC    = 24;
  localparam logic [7:0] PA = 8'h87;
  localparam logic [7:0] CA = 8'hD9;
  localparam int NVEC = 10;

  // {exp_cpu, exp_per, ew, tag[3:0], wdata[7:0], exp_read[7:0]}
  localparam logic [22:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 1'b1, 4'd2,  8'h80, 8'h80},  // R2 baud double
    {1'b1, 1'b1, 1'b1, 4'd2,  8'h0C, 8'h0C},  // R2 flags
    {1'b1, 1'b1, 1'b1, 4'd2,  8'h40, 8'h00},  // R2 reserved bit
    {1'b0, 1'b1, 1'b1, 4'd5,  8'h01, 8'h01},  // R5 idle
    {1'b0, 1'b0, 1'b1, 4'd3,  8'h03, 8'h02},  // R3 both set
    {1'b1, 1'b1, 1'b0, 4'd4,  8'h02, 8'h00},  // R4 blocked
    {1'b0, 1'b1, 1'b0, 4'd4,  8'h03, 8'h01},  // R4 blocked, idle taken
    {1'b0, 1'b1, 1'b1, 4'd2,  8'h0D, 8'h0D},  // R2 flags with idle
    {1'b1, 1'b1, 1'b1, 4'd10, 8'h20, 8'h20},  // R10 suppress bit
    {1'b1, 1'b1, 1'b1, 4'd9,  8'h10, 8'h10}   // R9 permission bit
  };

  logic       clk_i = 1'b0;
  logic       rst_i = 1'b1;
  logic       ext_rst_i = 1'b0;
  logic       wdt_ovf_i = 1'b0;
  logic       ew_i = 1'b1;
  logic       reg_wr_i = 1'b0;
  logic [7:0] reg_addr_i = 8'h00;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o;
  logic [3:0] irq_req_i = 4'h0;
  logic [3:0] irq_en_i = 4'h0;
  logic       wdt_load_i = 1'b0;
  logic       wdt_reload_o;
  logic       ale_i = 1'b0;
  logic       ale_o;
  logic [1:0] can_rx_i = 2'b11;
  logic       baud_dbl_o, cpu_clk_en_o, periph_clk_en_o, can_clk_en_o, sys_rst_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  pwr_mode_ctrl #(.RST_CYCLES(RST_CYC)) dut_i (
    .clk_i(clk_i), .rst_i(rst_i), .ext_rst_i(ext_rst_i), .wdt_ovf_i(wdt_ovf_i),
    .ew_i(ew_i), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .irq_req_i(irq_req_i), .irq_en_i(irq_en_i), .wdt_load_i(wdt_load_i),
    .wdt_reload_o(wdt_reload_o), .ale_i(ale_i), .ale_o(ale_o),
    .can_rx_i(can_rx_i), .baud_dbl_o(baud_dbl_o), .cpu_clk_en_o(cpu_clk_en_o),
    .periph_clk_en_o(periph_clk_en_o), .can_clk_en_o(can_clk_en_o),
    .sys_rst_o(sys_rst_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic por();
    rst_i = 1'b1;
    repeat (2) @(negedge clk_i);
    rst_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    // R1 reset state
    @(negedge clk_i);
    chk("R1 sys_rst during reset", sys_rst_o, 1);
    por();
    chk("R1 sys_rst released", sys_rst_o, 0);
    rd(PA, r); chk("R1 pcon", r, 8'h00);
    rd(CA, r); chk("R1 can reg", r, 8'h00);
    chk("R1 clock enables", {cpu_clk_en_o, periph_clk_en_o, can_clk_en_o}, 3'b111);

    // table walk: R2 R3 R4 R5 R9 R10 register effects
    for (int i = 0; i < NVEC; i++) begin
      por();
      ew_i = VEC[i][20];
      wr(PA, VEC[i][15:8]);
      rd(PA, r);
      chk($sformatf("R%0d vec %0d read", VEC[i][19:16], i), r, VEC[i][7:0]);
      chk($sformatf("R%0d vec %0d cpu_en", VEC[i][19:16], i), cpu_clk_en_o, VEC[i][22]);
      chk($sformatf("R%0d vec %0d per_en", VEC[i][19:16], i), periph_clk_en_o, VEC[i][21]);
      if (i == 0) chk("R2 baud_dbl_o", baud_dbl_o, 1);
      if (i == 4) chk("R3 can_en in power-down", can_clk_en_o, 0);
    end
    ew_i = 1'b1;

    // R6 interrupt wake
    por();
    wr(PA, 8'h01);
    irq_req_i = 4'b0100; irq_en_i = 4'b1011;
    repeat (3) @(negedge clk_i);
    chk("R6 disabled irq keeps idle", cpu_clk_en_o, 0);
    irq_en_i = 4'b0100;
    @(negedge clk_i);
    chk("R6 wake cpu_en", cpu_clk_en_o, 1);
    rd(PA, r); chk("R6 idle bit cleared", r, 8'h00);
    irq_req_i = 4'h0; irq_en_i = 4'h0;

    // R12 interrupt does not end power-down
    por();
    wr(PA, 8'h02);
    irq_req_i = 4'h1; irq_en_i = 4'h1;
    repeat (2) @(negedge clk_i);
    rd(PA, r); chk("R12 pd remains", r, 8'h02);
    chk("R12 per_en off", periph_clk_en_o, 0);
    irq_req_i = 4'h0; irq_en_i = 4'h0;

    // R7 short pulse ignored, full pulse resets
    por();
    wr(PA, 8'h01);
    ext_rst_i = 1'b1;
    repeat (RST_CYC - 1) @(negedge clk_i);
    chk("R7 23 cycles no reset", sys_rst_o, 0);
    ext_rst_i = 1'b0;
    @(negedge clk_i);
    rd(PA, r); chk("R7 idle kept after short pulse", r, 8'h01);
    ext_rst_i = 1'b1;
    repeat (RST_CYC - 1) @(negedge clk_i);
    chk("R7 before 24th edge", sys_rst_o, 0);
    @(negedge clk_i);
    chk("R7 reset at 24th edge", sys_rst_o, 1);
    rd(PA, r); chk("R7 idle cleared", r, 8'h00);
    ext_rst_i = 1'b0;
    @(negedge clk_i);
    chk("R7 release", sys_rst_o, 0);

    // R8 watchdog overflow
    wr(PA, 8'h02);
    wdt_ovf_i = 1'b1;
    @(negedge clk_i);
    wdt_ovf_i = 1'b0;
    chk("R8 sys_rst", sys_rst_o, 1);
    rd(PA, r); chk("R8 pd cleared", r, 8'h00);
    chk("R8 cpu_en", cpu_clk_en_o, 1);

    // R9 watchdog reload permission
    por();
    wdt_load_i = 1'b1;
    @(negedge clk_i);
    wdt_load_i = 1'b0;
    chk("R9 refused load", wdt_reload_o, 0);
    wr(PA, 8'h10);
    wdt_load_i = 1'b1;
    @(negedge clk_i);
    wdt_load_i = 1'b0;
    chk("R9 accepted pulse", wdt_reload_o, 1);
    rd(PA, r); chk("R9 permission cleared", r, 8'h00);
    @(negedge clk_i);
    chk("R9 pulse one cycle", wdt_reload_o, 0);

    // R10 ALE suppression
    ale_i = 1'b1;
    @(negedge clk_i);
    chk("R10 ale follows", ale_o, 1);
    wr(PA, 8'h20);
    @(negedge clk_i);
    chk("R10 ale held low", ale_o, 0);
    ale_i = 1'b0;

    // R11 CAN sleep
    por();
    wr(CA, 8'h10);
    rd(CA, r); chk("R11 sleep read", r, 8'h10);
    chk("R11 can_en off", can_clk_en_o, 0);
    wr(CA, 8'h00);
    rd(CA, r); chk("R11 write 0 clears", r, 8'h00);
    wr(CA, 8'h10);
    can_rx_i = 2'b10;
    @(negedge clk_i);
    rd(CA, r); chk("R11 rx0 dominant clears", r, 8'h00);
    can_rx_i = 2'b11;
    wr(CA, 8'h10);
    can_rx_i = 2'b01;
    @(negedge clk_i);
    rd(CA, r); chk("R11 rx1 dominant clears", r, 8'h00);
    chk("R11 can_en back", can_clk_en_o, 1);
    can_rx_i = 2'b11;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule